// File: doc/BRIEF.md
# Data Watchpoint Trace Comparator

This block is one comparator slot of a debug unit. Software (or a debugger) programs a 32-bit compare address and a function setting through a small register write port. The slot then watches every data-bus access presented on its monitor inputs, together with the program counter (PC) of the current instruction. When the access or the PC equals the compare address, the programmed function decides what happens: a one-cycle halt request for the debug core, a one-cycle trigger pulse for an external trace macrocell, or a trace packet holding the PC, the data value, the low address offset, or an address/data pair.

Trace packets leave through a valid/ready handshake, one 32-bit payload word per beat with a 2-bit kind tag. A packet with two fields is sent as two beats. The data field is left out when the access faulted, and the PC field is left out when the access was not the first address of a burst. If both fields are left out, no packet is sent. A small state machine with the states IDLE, BEAT_A and BEAT_B sequences the beats. It moves IDLE→BEAT_A when a trace event with at least one field is captured, BEAT_A→BEAT_B on a handshake when a second field is pending, BEAT_A→IDLE on a handshake when there is none, and BEAT_B→IDLE on a handshake.

Top module: `dwt_cmp_slot`

## Requirements
- R1: After reset the function code is 0 and the compare address is 0. With code 0 the slot raises no halt pulse, no trigger pulse and no packet, even on a matching access.
- R2: A write with `cfg_sel`=0 loads `cfg_wdata` as the compare address. A write with `cfg_sel`=1 loads the function code from `cfg_wdata[3:0]` and the emit-range flag from `cfg_wdata[8]`, and ignores the other bits. A new setting applies to accesses sampled on later clock edges.
- R3: A match is sampled only when `acc_valid` is high. A data match needs `acc_addr` to equal the compare address exactly and the access direction (`acc_write`=1 for write) to be one the code accepts. A PC match (codes 4 and 8) needs `cur_pc` to equal the compare address.
- R4: Codes 4, 5, 6 and 7 give a watchpoint on PC match, read match, write match and read-or-write match. `halt_pulse` is high for the one cycle after the clock edge that sampled the access.
- R5: Codes 8, 9, 10 and 11 give the same four match kinds on `trig_pulse`, with the same timing.
- R6: Trace codes react to both directions (1, 2, 3), to reads only (12, 14) or to writes only (13, 15). With emit-range 0 the fields are: 1 = PC; 2 = data; 3, 14, 15 = PC then data; 12, 13 = data. With emit-range 1 the fields are: 1, 12, 13 = offset; 2, 3, 14, 15 = offset then data.
- R7: The data field is dropped when `acc_fault` is high. The PC field and the offset field are kept on a faulting access.
- R8: The PC field is dropped when `acc_first` is low (not the first address of a burst).
- R9: A packet beat has kind encoding 0 = PC, 1 = offset, 2 = data. The first beat appears with `pkt_valid` in the cycle after the sampling edge. A second beat follows the handshake of the first. Kind and word stay stable while `pkt_valid` is high and `pkt_ready` is low.
- R10: A trace event sampled while a packet is still pending (state not IDLE) is dropped. The pending packet keeps its original contents.
- R11: The offset word is the low 16 bits of `acc_addr`, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = compare address, 1 = function setting |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_addr | input | 32 | Data address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_data | input | 32 | Data value of the access |
| acc_fault | input | 1 | Access faulted |
| acc_first | input | 1 | First address of a burst |
| cur_pc | input | 32 | Program counter of the current instruction |
| halt_pulse | output | 1 | Watchpoint debug event |
| trig_pulse | output | 1 | External trace trigger |
| pkt_valid | output | 1 | Trace beat valid |
| pkt_ready | input | 1 | Trace sink accepts beat |
| pkt_kind | output | 2 | Beat kind tag |
| pkt_word | output | 32 | Beat payload |

## Verification
The hardest case to reach is a second trace event that arrives while a two-beat packet is held by back-pressure. The case is only visible when the sink stalls across several cycles and the second access carries different data. The bench holds `pkt_ready` low and issues a second matching access during the stall. It then checks that the held first beat never changes, that the data beat released afterwards carries the first access's data, and that no third beat follows. The fault and burst-position filters are reached by table rows that combine each trace code with a faulting access or a non-first access.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    typedef enum logic [1:0] {
        PK_PC   = 2'd0,
        PK_OFF  = 2'd1,
        PK_DATA = 2'd2
    } pkt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BEAT_A = 2'd1,
        ST_BEAT_B = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic wp;      // raise halt pulse
        logic trig;    // raise trigger pulse
        logic trace;   // form a packet
        logic pc_cmp;  // compare PC instead of data address
        logic on_rd;   // accept reads
        logic on_wr;   // accept writes
        logic f_pc;    // packet carries PC
        logic f_off;   // packet carries address offset
        logic f_data;  // packet carries data value
    } action_t;

endpackage

// File: rtl/dwt_cfg_regs.sv
module dwt_cfg_regs #(
    parameter int WORD_W    = 32,
    parameter int CODE_W    = 4,
    parameter int RANGE_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cmp_addr,
    output logic [CODE_W-1:0] code,
    output logic              emit_rng
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_addr <= '0;
            code     <= '0;
            emit_rng <= 1'b0;
        end else if (cfg_we) begin
            if (!cfg_sel) begin
                cmp_addr <= cfg_wdata;
            end else begin
                code     <= cfg_wdata[CODE_W-1:0];
                emit_rng <= cfg_wdata[RANGE_BIT];
            end
        end
    end

endmodule

// File: rtl/dwt_action_decode.sv
module dwt_action_decode
    import dwt_pkg::*;
(
    input  logic [3:0] code,
    input  logic       emit_rng,
    output action_t    act
);

    always_comb begin
        act = '0;
        unique case (code)
            4'd0: begin
                act = '0;
            end
            4'd1: begin
                act.trace = 1'b1;
                act.on_rd = 1'b1;
                act.on_wr = 1'b1;
                act.f_pc  = !emit_rng;
                act.f_off = emit_rng;
            end
            4'd2: begin
                act.trace  = 1'b1;
                act.on_rd  = 1'b1;
                act.on_wr  = 1'b1;
                act.f_off  = emit_rng;
                act.f_data = 1'b1;
            end
            4'd3: begin
                act.trace  = 1'b1;
                act.on_rd  = 1'b1;
                act.on_wr  = 1'b1;
                act.f_pc   = !emit_rng;
                act.f_off  = emit_rng;
                act.f_data = 1'b1;
            end
            4'd4, 4'd8: begin
                act.wp     = (code == 4'd4);
                act.trig   = (code == 4'd8);
                act.pc_cmp = 1'b1;
            end
            4'd5, 4'd9: begin
                act.wp    = (code == 4'd5);
                act.trig  = (code == 4'd9);
                act.on_rd = 1'b1;
            end
            4'd6, 4'd10: begin
                act.wp    = (code == 4'd6);
                act.trig  = (code == 4'd10);
                act.on_wr = 1'b1;
            end
            4'd7, 4'd11: begin
                act.wp    = (code == 4'd7);
                act.trig  = (code == 4'd11);
                act.on_rd = 1'b1;
                act.on_wr = 1'b1;
            end
            4'd12, 4'd13: begin
                act.trace  = 1'b1;
                act.on_rd  = (code == 4'd12);
                act.on_wr  = (code == 4'd13);
                act.f_off  = emit_rng;
                act.f_data = !emit_rng;
            end
            4'd14, 4'd15: begin
                act.trace  = 1'b1;
                act.on_rd  = (code == 4'd14);
                act.on_wr  = (code == 4'd15);
                act.f_pc   = !emit_rng;
                act.f_off  = emit_rng;
                act.f_data = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dwt_match.sv
module dwt_match
    import dwt_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  action_t           act,
    input  logic [WORD_W-1:0] cmp_addr,
    input  logic              acc_valid,
    input  logic [WORD_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [WORD_W-1:0] cur_pc,
    output logic              hit
);

    logic addr_eq;
    logic pc_eq;
    logic dir_ok;

    always_comb begin
        addr_eq = (acc_addr == cmp_addr);
        pc_eq   = (cur_pc == cmp_addr);
        dir_ok  = acc_write ? act.on_wr : act.on_rd;
        if (!acc_valid) begin
            hit = 1'b0;
        end else if (act.pc_cmp) begin
            hit = pc_eq;
        end else begin
            hit = addr_eq && dir_ok;
        end
    end

endmodule

// File: rtl/dwt_pkt_fsm.sv
module dwt_pkt_fsm
    import dwt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_trace,
    input  action_t           act,
    input  logic              acc_fault,
    input  logic              acc_first,
    input  logic [WORD_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] acc_data,
    input  logic [WORD_W-1:0] cur_pc,
    input  logic              pkt_ready,
    output logic              pkt_valid,
    output logic [1:0]        pkt_kind,
    output logic [WORD_W-1:0] pkt_word
);

    localparam int PAD_W = WORD_W - OFF_W;

    tx_state_e         state_q, state_d;
    pkt_kind_e         kind_a_q, kind_b_q;
    logic [WORD_W-1:0] word_a_q, word_b_q;
    logic              two_q;

    logic              use_pc, use_off, use_data;
    logic              any_field, lead_field;
    logic              load;
    pkt_kind_e         kind_a_d;
    logic [WORD_W-1:0] word_a_d;
    logic [WORD_W-1:0] off_word;

    always_comb begin
        off_word   = {{PAD_W{1'b0}}, acc_addr[OFF_W-1:0]};
        use_pc     = act.f_pc && acc_first;
        use_off    = act.f_off;
        use_data   = act.f_data && !acc_fault;
        lead_field = use_pc || use_off;
        any_field  = lead_field || use_data;
        load       = ev_trace && any_field && (state_q == ST_IDLE);
        if (use_pc) begin
            kind_a_d = PK_PC;
            word_a_d = cur_pc;
        end else if (use_off) begin
            kind_a_d = PK_OFF;
            word_a_d = off_word;
        end else begin
            kind_a_d = PK_DATA;
            word_a_d = acc_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) state_d = ST_BEAT_A;
            end
            ST_BEAT_A: begin
                if (pkt_ready) state_d = two_q ? ST_BEAT_B : ST_IDLE;
            end
            ST_BEAT_B: begin
                if (pkt_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_a_q <= PK_PC;
            kind_b_q <= PK_DATA;
            word_a_q <= '0;
            word_b_q <= '0;
            two_q    <= 1'b0;
        end else if (load) begin
            kind_a_q <= kind_a_d;
            word_a_q <= word_a_d;
            kind_b_q <= PK_DATA;
            word_b_q <= acc_data;
            two_q    <= lead_field && use_data;
        end
    end

    always_comb begin
        pkt_valid = 1'b0;
        pkt_kind  = kind_a_q;
        pkt_word  = word_a_q;
        unique case (state_q)
            ST_IDLE: begin
                pkt_valid = 1'b0;
            end
            ST_BEAT_A: begin
                pkt_valid = 1'b1;
            end
            ST_BEAT_B: begin
                pkt_valid = 1'b1;
                pkt_kind  = kind_b_q;
                pkt_word  = word_b_q;
            end
            default: pkt_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/dwt_cmp_slot.sv
module dwt_cmp_slot
    import dwt_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int CODE_W    = 4,
    parameter int RANGE_BIT = 8,
    parameter int OFF_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [WORD_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [WORD_W-1:0] acc_data,
    input  logic              acc_fault,
    input  logic              acc_first,
    input  logic [WORD_W-1:0] cur_pc,
    output logic              halt_pulse,
    output logic              trig_pulse,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [1:0]        pkt_kind,
    output logic [WORD_W-1:0] pkt_word
);

    logic [WORD_W-1:0] cmp_addr;
    logic [CODE_W-1:0] cfg_code;
    logic              emit_rng;
    action_t           act;
    logic              hit;

    dwt_cfg_regs #(
        .WORD_W    (WORD_W),
        .CODE_W    (CODE_W),
        .RANGE_BIT (RANGE_BIT)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cmp_addr  (cmp_addr),
        .code      (cfg_code),
        .emit_rng  (emit_rng)
    );

    dwt_action_decode i_dec (
        .code     (cfg_code),
        .emit_rng (emit_rng),
        .act      (act)
    );

    dwt_match #(
        .WORD_W (WORD_W)
    ) i_match (
        .act       (act),
        .cmp_addr  (cmp_addr),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .cur_pc    (cur_pc),
        .hit       (hit)
    );

    dwt_pkt_fsm #(
        .WORD_W (WORD_W),
        .OFF_W  (OFF_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_trace  (hit && act.trace),
        .act       (act),
        .acc_fault (acc_fault),
        .acc_first (acc_first),
        .acc_addr  (acc_addr),
        .acc_data  (acc_data),
        .cur_pc    (cur_pc),
        .pkt_ready (pkt_ready),
        .pkt_valid (pkt_valid),
        .pkt_kind  (pkt_kind),
        .pkt_word  (pkt_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_pulse <= 1'b0;
            trig_pulse <= 1'b0;
        end else begin
            halt_pulse <= hit && act.wp;
            trig_pulse <= hit && act.trig;
        end
    end

endmodule

// File: rtl/dwt_cmp_checker.sv
module dwt_cmp_checker #(
    parameter int WORD_W = 32,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [CODE_W-1:0] cfg_code,
    input logic              halt_pulse,
    input logic              trig_pulse,
    input logic              pkt_valid,
    input logic              pkt_ready,
    input logic [1:0]        pkt_kind,
    input logic [WORD_W-1:0] pkt_word
);

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_code == '0) && $past(cfg_code == '0) |-> !halt_pulse && !trig_pulse); // R1

    AST_PULSE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_pulse || trig_pulse) |-> $past(acc_valid)); // R3

    AST_HALT_TRIG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_pulse && trig_pulse)); // R4

    AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_kind) && $stable(pkt_word)); // R9

    AST_PKT_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_kind != 2'd3)); // R9

    AST_OFF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && (pkt_kind == 2'd1) |-> (pkt_word[WORD_W-1:16] == '0)); // R11

endmodule

bind dwt_cmp_slot dwt_cmp_checker #(
    .WORD_W (WORD_W),
    .CODE_W (CODE_W)
) i_dwt_cmp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .cfg_code   (cfg_code),
    .halt_pulse (halt_pulse),
    .trig_pulse (trig_pulse),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_kind   (pkt_kind),
    .pkt_word   (pkt_word)
);

// File: tb/test_dwt_cmp_slot.sv
module test_dwt_cmp_slot;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CMP_A  = 32'h2000_5A3C;
    localparam logic [31:0] CMP_B  = 32'h3000_0104;
    localparam logic [31:0] OTHER  = 32'h2000_5A40;
    localparam logic [31:0] PC_DEF = 32'h0000_0ABC;
    localparam int NVEC = 30;

    // flags: {rng, wr, flt, fst, hit, exp_halt, exp_trig}; kinds 0=PC 1=OFF 2=DATA
    typedef struct packed {
        logic [3:0] code;
        logic [6:0] f;
        logic [1:0] n;
        logic [1:0] k0;
        logic [1:0] k1;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{4'd0,  7'b0001100, 2'd0, 2'd0, 2'd0},  // R1 disabled
        '{4'd4,  7'b0001110, 2'd0, 2'd0, 2'd0},  // R4 PC match
        '{4'd4,  7'b0001000, 2'd0, 2'd0, 2'd0},  // R4 PC miss
        '{4'd5,  7'b0001110, 2'd0, 2'd0, 2'd0},  // R4 read
        '{4'd5,  7'b0101100, 2'd0, 2'd0, 2'd0},  // R3 write on read-only
        '{4'd6,  7'b0101110, 2'd0, 2'd0, 2'd0},  // R4 write
        '{4'd7,  7'b0101110, 2'd0, 2'd0, 2'd0},  // R4 rw
        '{4'd7,  7'b0001000, 2'd0, 2'd0, 2'd0},  // R3 address miss
        '{4'd8,  7'b0001101, 2'd0, 2'd0, 2'd0},  // R5 PC
        '{4'd9,  7'b0001101, 2'd0, 2'd0, 2'd0},  // R5 read
        '{4'd10, 7'b0001100, 2'd0, 2'd0, 2'd0},  // R5 read on write-only
        '{4'd11, 7'b0101101, 2'd0, 2'd0, 2'd0},  // R5 rw
        '{4'd1,  7'b0001100, 2'd1, 2'd0, 2'd0},  // R6 PC
        '{4'd1,  7'b1101100, 2'd1, 2'd1, 2'd0},  // R6 offset
        '{4'd1,  7'b0000100, 2'd0, 2'd0, 2'd0},  // R8 not first
        '{4'd2,  7'b0101100, 2'd1, 2'd2, 2'd0},  // R6 data
        '{4'd2,  7'b1001100, 2'd2, 2'd1, 2'd2},  // R6 off+data
        '{4'd2,  7'b0011100, 2'd0, 2'd0, 2'd0},  // R7 fault
        '{4'd3,  7'b0001100, 2'd2, 2'd0, 2'd2},  // R6 pc+data
        '{4'd3,  7'b0011100, 2'd1, 2'd0, 2'd0},  // R7 PC kept
        '{4'd3,  7'b1101100, 2'd2, 2'd1, 2'd2},  // R6 off+data
        '{4'd12, 7'b0001100, 2'd1, 2'd2, 2'd0},  // R6 read data
        '{4'd12, 7'b0101100, 2'd0, 2'd0, 2'd0},  // R6 write ignored
        '{4'd12, 7'b1001100, 2'd1, 2'd1, 2'd0},  // R6 read offset
        '{4'd13, 7'b0101100, 2'd1, 2'd2, 2'd0},  // R6 write data
        '{4'd14, 7'b0001100, 2'd2, 2'd0, 2'd2},  // R6 pc+data read
        '{4'd14, 7'b1011100, 2'd1, 2'd1, 2'd0},  // R7 offset kept
        '{4'd15, 7'b0100100, 2'd1, 2'd2, 2'd0},  // R8 PC dropped
        '{4'd15, 7'b1101100, 2'd2, 2'd1, 2'd2},  // R6 off+data write
        '{4'd3,  7'b0001000, 2'd0, 2'd0, 2'd0}   // R3 miss
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_sel;
    logic [31:0] cfg_wdata;
    logic        acc_valid, acc_write, acc_fault, acc_first;
    logic [31:0] acc_addr, acc_data, cur_pc;
    logic        halt_pulse, trig_pulse, pkt_valid, pkt_ready;
    logic [1:0]  pkt_kind;
    logic [31:0] pkt_word;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwt_cmp_slot i_dwt_cmp_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .acc_write  (acc_write),
        .acc_data   (acc_data),
        .acc_fault  (acc_fault),
        .acc_first  (acc_first),
        .cur_pc     (cur_pc),
        .halt_pulse (halt_pulse),
        .trig_pulse (trig_pulse),
        .pkt_valid  (pkt_valid),
        .pkt_ready  (pkt_ready),
        .pkt_kind   (pkt_kind),
        .pkt_word   (pkt_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [1:0] k);
        case (k)
            2'd0:    return cur_pc;
            2'd1:    return {16'h0000, acc_addr[15:0]};
            default: return acc_data;
        endcase
    endfunction

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_beat(input string req, input logic [1:0] k);
        chk({req, " valid"}, {31'd0, pkt_valid}, 32'd1);
        chk({req, " kind"}, {30'd0, pkt_kind}, {30'd0, k});
        chk({req, " word"}, pkt_word, exp_word(k));
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        string tag;
        v = VEC[i];
        tag = $sformatf("R6/vec%0d", i);
        cfg_write(1'b1, {23'd0, v.f[6], 4'd0, v.code});
        // now at a negedge with cfg_we low
        acc_write = v.f[5];
        acc_fault = v.f[4];
        acc_first = v.f[3];
        acc_data  = 32'hD000_0000 + i;
        if (v.f[2] && (v.code == 4'd4 || v.code == 4'd8)) begin
            cur_pc = CMP_A; acc_addr = OTHER;
        end else if (v.f[2]) begin
            cur_pc = PC_DEF; acc_addr = CMP_A;
        end else begin
            cur_pc = PC_DEF; acc_addr = OTHER;
        end
        acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        chk($sformatf("R4 halt vec%0d", i), {31'd0, halt_pulse}, {31'd0, v.f[1]});
        chk($sformatf("R5 trig vec%0d", i), {31'd0, trig_pulse}, {31'd0, v.f[0]});
        if (v.n != 2'd0) check_beat({tag, " beat0"}, v.k0);
        else chk({tag, " R9 no packet"}, {31'd0, pkt_valid}, 32'd0);
        @(negedge clk);
        chk($sformatf("R4 halt one cycle vec%0d", i), {31'd0, halt_pulse}, 32'd0);
        chk($sformatf("R5 trig one cycle vec%0d", i), {31'd0, trig_pulse}, 32'd0);
        if (v.n == 2'd2) begin
            check_beat({tag, " beat1"}, v.k1);
            @(negedge clk);
        end
        chk({tag, " R9 end of packet"}, {31'd0, pkt_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_fault = 1'b0; acc_first = 1'b1;
        acc_addr = '0; acc_data = '0; cur_pc = '0; pkt_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset halt", {31'd0, halt_pulse}, 32'd0);
        chk("R1 reset trig", {31'd0, trig_pulse}, 32'd0);
        chk("R1 reset pkt_valid", {31'd0, pkt_valid}, 32'd0);
        rst_n = 1'b1;

        // R1: after reset, code 0 and address 0: access at address 0 gives nothing
        @(negedge clk);
        acc_addr = 32'h0; cur_pc = 32'h0; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R1 reset code silent halt", {31'd0, halt_pulse}, 32'd0);
        chk("R1 reset code silent pkt", {31'd0, pkt_valid}, 32'd0);

        cfg_write(1'b0, CMP_A);
        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R2: new address, upper function bits ignored (code 5, range 0)
        cfg_write(1'b0, CMP_B);
        cfg_write(1'b1, 32'hFFFF_FE05);
        acc_addr = CMP_A; acc_write = 1'b0; acc_first = 1'b1; acc_fault = 1'b0; acc_valid = 1'b1;
        @(negedge clk);
        chk("R2 old address no longer matches", {31'd0, halt_pulse}, 32'd0);
        acc_addr = CMP_B;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R2 new address and code 5 halt", {31'd0, halt_pulse}, 32'd1);
        chk("R2 code 5 is not a trigger", {31'd0, trig_pulse}, 32'd0);

        // R9/R10: back-pressure with a second event during the stall
        cfg_write(1'b1, 32'h0000_0003);
        pkt_ready = 1'b0;
        acc_addr = CMP_B; cur_pc = 32'h0000_4444; acc_data = 32'hAAAA_0001; acc_valid = 1'b1;
        @(negedge clk);
        check_beat("R9 stalled beat0", 2'd0);
        acc_data = 32'hBBBB_0002; cur_pc = 32'h0000_5555;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R9 held kind", {30'd0, pkt_kind}, 32'd0);
        chk("R10 held word keeps first PC", pkt_word, 32'h0000_4444);
        @(negedge clk);
        chk("R9 still valid under stall", {31'd0, pkt_valid}, 32'd1);
        pkt_ready = 1'b1;
        @(negedge clk);
        chk("R9 second beat kind data", {30'd0, pkt_kind}, 32'd2);
        chk("R10 second beat carries first data", pkt_word, 32'hAAAA_0001);
        @(negedge clk);
        chk("R10 dropped event gives no packet", {31'd0, pkt_valid}, 32'd0);

        // R11: offset of a high address is zero-extended
        cfg_write(1'b0, 32'hFFFF_8001);
        cfg_write(1'b1, 32'h0000_0101);
        acc_addr = 32'hFFFF_8001; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R11 offset word", pkt_word, 32'h0000_8001);
        chk("R11 offset kind", {30'd0, pkt_kind}, 32'd1);
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule